// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Sequencer

This block finds the source operand of a two-operand register-accumulate instruction. It receives an instruction that has already been decoded: an addressing-mode code, a destination register number, a base and an index register number, a constant (used as an immediate value, an absolute address or a displacement) and a 2-bit scale code. It reads a small general-purpose register file that it holds itself. When the mode needs memory, it sends read requests to a data memory, one at a time, over a request/valid handshake. When the operand is known it raises a one-cycle completion strobe and shows the operand and the sum of the destination register and the operand.

If the accumulate enable was set with the instruction, that sum is written back into the destination register. The registers can only be changed this way. Software therefore loads a value by accumulating an immediate into a register that still holds zero, and reads a register back through register mode. Memory-indirect mode needs two memory reads, one after the other: the data returned by the first read becomes the address of the second.

Top module: `opnd_fetch`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and every register reads as zero.
- R2: Mode code 0 (immediate) takes `konst` as the operand. Mode code 7 behaves the same way. `done` rises one cycle after the start is accepted and no memory request is made.
- R3: Mode code 1 (register) takes the content of register `base_sel` as the operand, with `done` one cycle after the start. Register 0 always reads as zero.
- R4: Mode code 2 (register-indirect) makes exactly one read, at the low `AW` bits of register `base_sel`, and takes the returned word as the operand.
- R5: Mode code 3 (direct) makes exactly one read, at the low `AW` bits of `konst`.
- R6: Mode code 4 (memory-indirect) first reads at register `base_sel`. It then reads at the low `AW` bits of the word that comes back, and takes the second returned word as the operand.
- R7: Mode code 5 (displacement) reads at `konst + reg[base_sel]`. With base register 0 this reads at the absolute address `konst`.
- R8: Mode code 6 (scaled) reads at `konst + reg[base_sel] + (reg[index_sel] << scale)`. The scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R9: `result` equals the destination register plus the operand, and is shown together with `done`. When `acc_en` is set, that sum is written into register `dst_sel` and the next instruction sees it. A write to register 0 leaves it at zero.
- R10: `mem_req` is asserted only while `busy`, and only when no earlier request is still waiting for its `mem_rvalid`. Each request is a one-cycle pulse.
- R11: `done` is asserted for exactly one cycle for each accepted instruction. `operand` and `result` are valid in that cycle.
- R12: A `start` that arrives while `busy` is high is ignored. It produces no `done` and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present; accepted when not busy |
| mode | input | 3 | Addressing-mode code |
| dst_sel | input | RW | Destination (accumulate) register number |
| base_sel | input | RW | Base register number |
| index_sel | input | RW | Index register number |
| konst | input | DW | Immediate, absolute address or displacement |
| scale | input | 2 | Index shift amount (times 1/2/4/8) |
| acc_en | input | 1 | Write result back to the destination register |
| busy | output | 1 | Instruction in progress (waiting on memory) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | AW | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| done | output | 1 | Operand ready strobe |
| operand | output | DW | Resolved source operand |
| result | output | DW | Destination register plus operand |

## Verification
A wrong address computation, or a wrong step in the fetch sequence, shows up at `mem_addr` on the very first request that follows it. The scoreboard compares every request address against a queue of expected addresses. If the fetch state machine takes the wrong step, the visible effect is a missing or extra memory request or `done` pulse, reported in that cycle.

A bad write-back leaves nothing wrong at the ports until some register is used again. The bench therefore reads registers back through register mode, or uses them as bases, straight after each accumulation. This keeps the distance between the corrupted register and the first wrong output to one instruction.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [2:0] {
        MODE_IMM  = 3'd0,
        MODE_REG  = 3'd1,
        MODE_RIND = 3'd2,
        MODE_ABS  = 3'd3,
        MODE_MIND = 3'd4,
        MODE_DISP = 3'd5,
        MODE_SCL  = 3'd6,
        MODE_RSV  = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT1 = 2'd1,
        ST_WAIT2 = 2'd2
    } st_e;

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra_a,
    input  logic [RW-1:0] ra_b,
    input  logic [RW-1:0] ra_c,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_c,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    // Register 0 is never stored; the read ports force it to zero.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
    assign rd_c = (ra_c == '0) ? '0 : regs_q[ra_c];

    AST_WB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wa != '0)); // R9

endmodule

// File: rtl/opf_agen.sv
module opf_agen
    import opf_pkg::*;
#(
    parameter int DW = 32
) (
    input  mode_e         mode,
    input  logic [DW-1:0] base_val,
    input  logic [DW-1:0] index_val,
    input  logic [DW-1:0] disp,
    input  logic [1:0]    scale,
    output logic [DW-1:0] ea
);

    logic [DW-1:0] scaled_idx;

    always_comb begin
        case (scale)
            2'd0:    scaled_idx = index_val;
            2'd1:    scaled_idx = {index_val[DW-2:0], 1'b0};
            2'd2:    scaled_idx = {index_val[DW-3:0], 2'b0};
            default: scaled_idx = {index_val[DW-4:0], 3'b0};
        endcase
    end

    always_comb begin
        case (mode)
            MODE_RIND, MODE_MIND: ea = base_val;
            MODE_ABS:             ea = disp;
            MODE_DISP:            ea = disp + base_val;
            MODE_SCL:             ea = disp + base_val + scaled_idx;
            default:              ea = '0;
        endcase
    end

endmodule

// File: rtl/opnd_fetch.sv
module opnd_fetch
    import opf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int NREG = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [RW-1:0] dst_sel,
    input  logic [RW-1:0] base_sel,
    input  logic [RW-1:0] index_sel,
    input  logic [DW-1:0] konst,
    input  logic [1:0]    scale,
    input  logic          acc_en,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] result
);

    typedef struct packed {
        st_e           st;
        mode_e         md;
        logic [RW-1:0] dst;
        logic          acc;
        logic          req;
        logic [AW-1:0] addr;
        logic          done;
        logic [DW-1:0] opnd;
        logic [DW-1:0] res;
    } seq_t;

    seq_t s_q, s_d;

    logic [DW-1:0] base_val, index_val, dst_val, ea;
    logic [RW-1:0] dst_rd_sel;
    logic          wb_we;
    logic [RW-1:0] wb_wa;
    logic [DW-1:0] wb_wd;
    mode_e         mode_in;

    assign mode_in    = mode_e'(mode);
    assign dst_rd_sel = (s_q.st == ST_IDLE) ? dst_sel : s_q.dst;

    opf_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (base_sel),
        .ra_b (index_sel),
        .ra_c (dst_rd_sel),
        .rd_a (base_val),
        .rd_b (index_val),
        .rd_c (dst_val),
        .we   (wb_we),
        .wa   (wb_wa),
        .wd   (wb_wd)
    );

    opf_agen #(.DW(DW)) u_agen (
        .mode     (mode_in),
        .base_val (base_val),
        .index_val(index_val),
        .disp     (konst),
        .scale    (scale),
        .ea       (ea)
    );

    logic          fin;
    logic [DW-1:0] fin_val;
    logic [RW-1:0] fin_dst;
    logic          fin_acc;

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.done = 1'b0;
        fin      = 1'b0;
        fin_val  = '0;
        fin_dst  = s_q.dst;
        fin_acc  = s_q.acc;

        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.md  = mode_in;
                    s_d.dst = dst_sel;
                    s_d.acc = acc_en;
                    fin_dst = dst_sel;
                    fin_acc = acc_en;
                    case (mode_in)
                        MODE_IMM, MODE_RSV: begin
                            fin     = 1'b1;
                            fin_val = konst;
                        end
                        MODE_REG: begin
                            fin     = 1'b1;
                            fin_val = base_val;
                        end
                        default: begin
                            s_d.req  = 1'b1;
                            s_d.addr = ea[AW-1:0];
                            s_d.st   = ST_WAIT1;
                        end
                    endcase
                end
            end
            ST_WAIT1: begin
                if (mem_rvalid) begin
                    if (s_q.md == MODE_MIND) begin
                        s_d.req  = 1'b1;
                        s_d.addr = mem_rdata[AW-1:0];
                        s_d.st   = ST_WAIT2;
                    end else begin
                        fin     = 1'b1;
                        fin_val = mem_rdata;
                        s_d.st  = ST_IDLE;
                    end
                end
            end
            ST_WAIT2: begin
                if (mem_rvalid) begin
                    fin     = 1'b1;
                    fin_val = mem_rdata;
                    s_d.st  = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        wb_we = 1'b0;
        wb_wa = fin_dst;
        wb_wd = dst_val + fin_val;
        if (fin) begin
            s_d.done = 1'b1;
            s_d.opnd = fin_val;
            s_d.res  = dst_val + fin_val;
            wb_we    = fin_acc && (fin_dst != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, md: MODE_IMM, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign mem_req  = s_q.req;
    assign mem_addr = s_q.addr;
    assign done     = s_q.done;
    assign operand  = s_q.opnd;
    assign result   = s_q.res;

    // Independent trackers for the handshake and instruction accounting.
    logic [1:0] outst_q;
    logic [1:0] pend_q;
    logic       accept;
    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
            pend_q  <= '0;
        end else begin
            outst_q <= outst_q + {1'b0, mem_req} - {1'b0, mem_rvalid && (outst_q != '0 || mem_req)};
            pend_q  <= pend_q + {1'b0, accept} - {1'b0, done};
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (outst_q == '0)); // R10
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R10
    AST_DONE_MATCHES_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend_q == 2'd1)); // R11
    AST_PEND_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q <= 2'd1)); // R12

endmodule

// File: tb/sim_opnd_fetch.sv
`timescale 1ns/1ps
module sim_opnd_fetch;

    localparam int DW = 32;
    localparam int AW = 16;
    localparam int NREG = 16;
    localparam int RW = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = '0;
    logic [RW-1:0] dst_sel = '0, base_sel = '0, index_sel = '0;
    logic [DW-1:0] konst = '0;
    logic [1:0]    scale = '0;
    logic          acc_en = 1'b0;
    logic          busy, mem_req, done;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] operand, result;

    always #2 clk = ~clk;

    opnd_fetch #(.DW(DW), .AW(AW), .NREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .dst_sel(dst_sel), .base_sel(base_sel), .index_sel(index_sel),
        .konst(konst), .scale(scale), .acc_en(acc_en), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .operand(operand), .result(result)
    );

    int checks = 0;
    int failures = 0;
    int mem_lat = 1;
    logic [DW-1:0] shadow [NREG];

    logic [DW-1:0] exp_opnd [$];
    logic [DW-1:0] exp_res [$];
    string         exp_tag [$];
    logic [AW-1:0] exp_addr [$];
    string         addr_tag [$];

    function automatic logic [DW-1:0] memd(input logic [AW-1:0] a);
        logic [15:0] lo;
        lo = 16'(a * 16'd3 + 16'h0040);
        return {a ^ 16'hFFFF, lo};
    endfunction

    function automatic logic [DW-1:0] rv(input logic [RW-1:0] r);
        return (r == '0) ? '0 : shadow[r];
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model and request monitor
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                logic [AW-1:0] a;
                a = mem_addr;
                if (exp_addr.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R10 unexpected request actual=%h expected=none", a);
                end else begin
                    string t;
                    logic [AW-1:0] e;
                    e = exp_addr.pop_front();
                    t = addr_tag.pop_front();
                    check({t, " addr"}, DW'(a), DW'(e));
                end
                repeat (mem_lat - 1) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = memd(a);
            end
        end
    end

    // Completion monitor (scoreboard)
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_opnd.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R11/R12 extra done actual=%h expected=none", operand);
                end else begin
                    string t;
                    logic [DW-1:0] eo, er;
                    eo = exp_opnd.pop_front();
                    er = exp_res.pop_front();
                    t  = exp_tag.pop_front();
                    check({t, " operand"}, operand, eo);
                    check({t, " result R9"}, result, er);
                end
            end
        end
    end

    function automatic void predict(input logic [2:0] m, input logic [RW-1:0] d,
                                    input logic [RW-1:0] b, input logic [RW-1:0] x,
                                    input logic [DW-1:0] k, input logic [1:0] s,
                                    input logic a, input string tag);
        logic [DW-1:0] op, ea;
        logic [AW-1:0] p;
        case (m)
            3'd0, 3'd7: op = k;
            3'd1: op = rv(b);
            3'd4: begin
                p = rv(b)[AW-1:0];
                exp_addr.push_back(p); addr_tag.push_back(tag);
                p = memd(p)[AW-1:0];
                exp_addr.push_back(p); addr_tag.push_back(tag);
                op = memd(p);
            end
            default: begin
                case (m)
                    3'd2: ea = rv(b);
                    3'd3: ea = k;
                    3'd5: ea = k + rv(b);
                    default: ea = k + rv(b) + (rv(x) * (DW'(1) << s));
                endcase
                exp_addr.push_back(ea[AW-1:0]); addr_tag.push_back(tag);
                op = memd(ea[AW-1:0]);
            end
        endcase
        exp_opnd.push_back(op);
        exp_res.push_back(rv(d) + op);
        exp_tag.push_back(tag);
        if (a && d != '0) shadow[d] = rv(d) + op;
    endfunction

    task automatic issue(input logic [2:0] m, input logic [RW-1:0] d,
                         input logic [RW-1:0] b, input logic [RW-1:0] x,
                         input logic [DW-1:0] k, input logic [1:0] s,
                         input logic a, input string tag);
        predict(m, d, b, x, k, s, a, tag);
        mode = m; dst_sel = d; base_sel = b; index_sel = x;
        konst = k; scale = s; acc_en = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", DW'(busy), 0);
        check("R1 done", DW'(done), 0);
        check("R1 mem_req", DW'(mem_req), 0);
        issue(3'd1, 4'd0, 4'd5, 4'd0, 0, 2'd0, 1'b0, "R1 reg5 zero");

        issue(3'd0, 4'd1, 4'd0, 4'd0, 32'h1234_5678, 2'd0, 1'b1, "R2 imm");
        issue(3'd7, 4'd2, 4'd0, 4'd0, 32'h0000_0055, 2'd0, 1'b1, "R2 code7");
        issue(3'd0, 4'd3, 4'd0, 4'd0, 32'h0000_0100, 2'd0, 1'b1, "R9 load r3");
        issue(3'd0, 4'd4, 4'd0, 4'd0, 32'h0000_0003, 2'd0, 1'b1, "R9 load r4");
        issue(3'd0, 4'd5, 4'd0, 4'd0, 32'h0001_0020, 2'd0, 1'b1, "R9 load r5");

        issue(3'd1, 4'd0, 4'd1, 4'd0, 0, 2'd0, 1'b0, "R3 reg r1");
        issue(3'd1, 4'd0, 4'd0, 4'd0, 0, 2'd0, 1'b0, "R3 reg r0");

        mem_lat = 1;
        issue(3'd2, 4'd0, 4'd3, 4'd0, 0, 2'd0, 1'b0, "R4 rind lat1");
        mem_lat = 3;
        issue(3'd2, 4'd0, 4'd5, 4'd0, 0, 2'd0, 1'b0, "R4 rind masked lat3");
        mem_lat = 2;
        issue(3'd3, 4'd0, 4'd0, 4'd0, 32'h0000_0ABC, 2'd0, 1'b0, "R5 direct");
        mem_lat = 1;
        issue(3'd4, 4'd0, 4'd3, 4'd0, 0, 2'd0, 1'b0, "R6 mind lat1");
        mem_lat = 3;
        issue(3'd4, 4'd1, 4'd4, 4'd0, 0, 2'd0, 1'b0, "R6 mind lat3");
        mem_lat = 1;
        issue(3'd5, 4'd0, 4'd3, 4'd0, 32'h0000_0010, 2'd0, 1'b0, "R7 disp");
        issue(3'd5, 4'd0, 4'd0, 4'd0, 32'h0000_2222, 2'd0, 1'b0, "R7 disp base0");
        for (int s = 0; s < 4; s++) begin
            issue(3'd6, 4'd0, 4'd3, 4'd4, 32'h0000_0004, 2'(s), 1'b0, "R8 scaled");
        end

        mem_lat = 2;
        issue(3'd3, 4'd6, 4'd0, 4'd0, 32'h0000_0010, 2'd0, 1'b1, "R9 acc mem");
        issue(3'd3, 4'd6, 4'd0, 4'd0, 32'h0000_0011, 2'd0, 1'b1, "R9 acc mem2");
        issue(3'd1, 4'd0, 4'd6, 4'd0, 0, 2'd0, 1'b0, "R9 readback r6");
        issue(3'd0, 4'd0, 4'd0, 4'd0, 32'h0000_7777, 2'd0, 1'b1, "R9 acc r0");
        issue(3'd1, 4'd0, 4'd0, 4'd0, 0, 2'd0, 1'b0, "R9 r0 stays zero");

        // R12: start while busy is ignored
        mem_lat = 4;
        predict(3'd3, 4'd0, 4'd0, 4'd0, 32'h0000_0300, 2'd0, 1'b0, "R12 first");
        mode = 3'd3; dst_sel = 4'd0; base_sel = 4'd0; konst = 32'h0000_0300; acc_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        mode = 3'd0; dst_sel = 4'd3; konst = 32'h0000_0999; acc_en = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        issue(3'd1, 4'd0, 4'd3, 4'd0, 0, 2'd0, 1'b0, "R12 r3 unchanged");

        repeat (3) @(negedge clk);
        check("R10 no pending request", DW'(exp_addr.size()), 0);
        check("R11 no pending done", DW'(exp_opnd.size()), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule